// File: doc/BRIEF.md
# Condition Register Logic Unit

This block holds a 32-bit condition register made of eight 4-bit flag fields and does all the work that touches it. A comparator outside the block hands over a set of flags and a field number, and the unit stores them. An operation port combines any two single bits of the register and writes the one-bit result back to any third bit. The same port can also copy one whole field onto another.

Software can read or replace the register as a single 32-bit word. A branch-test port picks a field and a condition, and one clock later the block reports whether the branch is taken. Instruction decode, the comparator and branch target arithmetic live elsewhere.

Every update lands on the next rising clock edge. A branch test in the same cycle sees the register as it was before that edge.

Top module: `crlu_top`

## Requirements
- R1: A clock edge with `rst` high clears the whole register to zero and drives `br_taken` low.
- R2: Field 0 is `rd_data[31:28]` and field 7 is `rd_data[3:0]`. Global bit index g (0..31) is `rd_data[31-g]`, with g = 4*field + position. Inside a field, position 0 is less-than, 1 is greater-than, 2 is equal and 3 is summary-overflow.
- R3: When `cmp_valid` is high, the flags {lt,gt,eq,so} go into field `cmp_field` if `cmp_named` is 1, and into field 0 if `cmp_named` is 0. All other fields keep their values.
- R4: When `op_valid` is high, op codes 0..6 apply the following to bits A and B: 0 AND, 1 OR, 2 NOR, 3 XOR, 4 XNOR, 5 A AND NOT B, 6 A OR NOT B. The result is written to bit D only, and both sources are read from the value before the edge.
- R5: With A equal to B, op 4 sets bit D and op 3 clears it. Op 1 copies bit A to D, and op 2 writes the inverse of A to D.
- R6: Op code 7 copies all four bits of field `op_a[2:0]` into field `op_d[2:0]`. The upper index bits are ignored, and every other field is left unchanged.
- R7: `wr_en` replaces all 32 bits with `wr_data` on the next edge. `rd_data` always shows the whole register.
- R8: `br_taken` is registered. One cycle after a test, it shows the result of `br_cond` on field `br_field` of the pre-edge register. The conditions are: 0 LT set, 1 GT set, 2 EQ set, 3 SO set, 4 GT or EQ set, 5 LT or EQ set, 6 EQ clear, 7 SO clear.
- R9: If several sources write in the same cycle, `wr_en` wins over `op_valid`, and `op_valid` wins over `cmp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_valid | input | 1 | Store compare flags this cycle |
| cmp_named | input | 1 | 1: use `cmp_field`; 0: use field 0 |
| cmp_field | input | 3 | Target field for compare flags |
| cmp_lt | input | 1 | Less-than flag |
| cmp_gt | input | 1 | Greater-than flag |
| cmp_eq | input | 1 | Equal flag |
| cmp_so | input | 1 | Summary-overflow flag from outside |
| op_valid | input | 1 | Execute an operation this cycle |
| op_code | input | 3 | Operation select (R4, R6) |
| op_a | input | 5 | Source bit A, or source field in its low 3 bits |
| op_b | input | 5 | Source bit B |
| op_d | input | 5 | Destination bit, or destination field in its low 3 bits |
| wr_en | input | 1 | Whole-register write |
| wr_data | input | 32 | Value for whole-register write |
| rd_data | output | 32 | Current register contents |
| br_field | input | 3 | Field to test |
| br_cond | input | 3 | Branch condition select |
| br_taken | output | 1 | Registered branch decision |

## Verification
The bench goes after several mapping and ordering mistakes, each of which shows up in a different way:
- **Bit or field order:** reversing the order of the bit index or the flag order inside a field would place a compare result on the wrong nibble. It would also flip which end of the word bit 0 names.
- **Self-referencing ops:** operations with A equal to B and D equal to A would show a design that reads the source after the write.
- **Unnamed compares:** an unnamed compare with a nonzero field number exposes a design that ignores `cmp_named`.
- **Field copy:** copies with nonzero upper index bits catch a design that decodes too many bits.
- **Branch timing and priority:** branch tests aimed at a field being written in the same cycle reveal a decision taken from the new value. Cycles with several write sources at once reveal a wrong priority.

// File: rtl/crlu_pkg.sv
package crlu_pkg;
  localparam int FLAG_W = 4;

  typedef enum logic [2:0] {
    OP_AND   = 3'd0,
    OP_OR    = 3'd1,
    OP_NOR   = 3'd2,
    OP_XOR   = 3'd3,
    OP_XNOR  = 3'd4,
    OP_ANDC  = 3'd5,
    OP_ORC   = 3'd6,
    OP_FMOVE = 3'd7
  } crlu_op_e;

  typedef enum logic [2:0] {
    BR_LT = 3'd0,
    BR_GT = 3'd1,
    BR_EQ = 3'd2,
    BR_SO = 3'd3,
    BR_GE = 3'd4,
    BR_LE = 3'd5,
    BR_NE = 3'd6,
    BR_NS = 3'd7
  } crlu_br_e;

  // position 0 (less-than) sits in the nibble MSB
  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } crlu_flags_t;
endpackage

// File: rtl/crlu_bitop.sv
module crlu_bitop
  import crlu_pkg::*;
#(
  parameter  int NUM_FIELDS = 8,
  localparam int REG_W      = NUM_FIELDS * FLAG_W,
  localparam int IDX_W      = $clog2(REG_W)
) (
  input  logic [REG_W-1:0] cr,
  input  logic [2:0]       code,
  input  logic [IDX_W-1:0] idx_a,
  input  logic [IDX_W-1:0] idx_b,
  output logic             res
);
  logic sa, sb;

  // global index g lives at register bit REG_W-1-g
  assign sa = cr[REG_W-1-int'(idx_a)];
  assign sb = cr[REG_W-1-int'(idx_b)];

  always_comb begin
    unique case (crlu_op_e'(code))
      OP_AND:  res = sa & sb;
      OP_OR:   res = sa | sb;
      OP_NOR:  res = ~(sa | sb);
      OP_XOR:  res = sa ^ sb;
      OP_XNOR: res = ~(sa ^ sb);
      OP_ANDC: res = sa & ~sb;
      OP_ORC:  res = sa | ~sb;
      default: res = 1'b0;
    endcase
  end
endmodule

// File: rtl/crlu_update.sv
module crlu_update
  import crlu_pkg::*;
#(
  parameter  int NUM_FIELDS = 8,
  localparam int REG_W      = NUM_FIELDS * FLAG_W,
  localparam int IDX_W      = $clog2(REG_W),
  localparam int FSEL_W     = $clog2(NUM_FIELDS)
) (
  input  logic [REG_W-1:0]  cr_q,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic [FSEL_W-1:0] src_field,
  input  logic [IDX_W-1:0]  op_d,
  input  logic              op_res,
  input  logic              cmp_valid,
  input  logic [FSEL_W-1:0] cmp_tgt,
  input  logic [FLAG_W-1:0] cmp_flags,
  output logic [REG_W-1:0]  cr_d
);
  logic [FLAG_W-1:0] src_nib;
  logic [FSEL_W-1:0] dst_field;
  logic              is_move;

  assign src_nib   = cr_q[(NUM_FIELDS-1-int'(src_field))*FLAG_W +: FLAG_W];
  assign dst_field = op_d[FSEL_W-1:0];
  assign is_move   = (crlu_op_e'(op_code) == OP_FMOVE);

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    for (genvar p = 0; p < FLAG_W; p++) begin : g_bit
      localparam int GIDX = f * FLAG_W + p;
      localparam int RPOS = REG_W - 1 - GIDX;
      logic nb;

      always_comb begin
        nb = cr_q[RPOS];
        if (wr_en) begin
          nb = wr_data[RPOS];
        end else if (op_valid) begin
          if (is_move) begin
            if (dst_field == FSEL_W'(f)) nb = src_nib[FLAG_W-1-p];
          end else if (op_d == IDX_W'(GIDX)) begin
            nb = op_res;
          end
        end else if (cmp_valid && (cmp_tgt == FSEL_W'(f))) begin
          nb = cmp_flags[FLAG_W-1-p];
        end
      end

      assign cr_d[RPOS] = nb;
    end
  end
endmodule

// File: rtl/crlu_branch.sv
module crlu_branch
  import crlu_pkg::*;
#(
  parameter  int NUM_FIELDS = 8,
  localparam int REG_W      = NUM_FIELDS * FLAG_W,
  localparam int FSEL_W     = $clog2(NUM_FIELDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_W-1:0]  cr,
  input  logic [FSEL_W-1:0] field,
  input  logic [2:0]        cond,
  output logic              taken
);
  crlu_flags_t fl;
  logic        hit;

  assign fl = crlu_flags_t'(cr[(NUM_FIELDS-1-int'(field))*FLAG_W +: FLAG_W]);

  always_comb begin
    unique case (crlu_br_e'(cond))
      BR_LT:   hit = fl.lt;
      BR_GT:   hit = fl.gt;
      BR_EQ:   hit = fl.eq;
      BR_SO:   hit = fl.so;
      BR_GE:   hit = fl.gt | fl.eq;
      BR_LE:   hit = fl.lt | fl.eq;
      BR_NE:   hit = ~fl.eq;
      default: hit = ~fl.so;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) taken <= 1'b0;
    else     taken <= hit;
  end
endmodule

// File: rtl/crlu_top.sv
module crlu_top
  import crlu_pkg::*;
#(
  parameter  int NUM_FIELDS = 8,
  localparam int REG_W      = NUM_FIELDS * FLAG_W,
  localparam int IDX_W      = $clog2(REG_W),
  localparam int FSEL_W     = $clog2(NUM_FIELDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmp_valid,
  input  logic              cmp_named,
  input  logic [FSEL_W-1:0] cmp_field,
  input  logic              cmp_lt,
  input  logic              cmp_gt,
  input  logic              cmp_eq,
  input  logic              cmp_so,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic [IDX_W-1:0]  op_a,
  input  logic [IDX_W-1:0]  op_b,
  input  logic [IDX_W-1:0]  op_d,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  input  logic [FSEL_W-1:0] br_field,
  input  logic [2:0]        br_cond,
  output logic              br_taken
);
  logic [REG_W-1:0]  cr_q, cr_d;
  logic              op_res;
  logic [FSEL_W-1:0] cmp_tgt;
  crlu_flags_t       cmp_flags;

  assign cmp_tgt   = cmp_named ? cmp_field : '0;
  assign cmp_flags = '{lt: cmp_lt, gt: cmp_gt, eq: cmp_eq, so: cmp_so};

  crlu_bitop #(.NUM_FIELDS(NUM_FIELDS)) bitop_i (
    .cr    (cr_q),
    .code  (op_code),
    .idx_a (op_a),
    .idx_b (op_b),
    .res   (op_res)
  );

  crlu_update #(.NUM_FIELDS(NUM_FIELDS)) update_i (
    .cr_q      (cr_q),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .src_field (op_a[FSEL_W-1:0]),
    .op_d      (op_d),
    .op_res    (op_res),
    .cmp_valid (cmp_valid),
    .cmp_tgt   (cmp_tgt),
    .cmp_flags (cmp_flags),
    .cr_d      (cr_d)
  );

  always_ff @(posedge clk) begin
    if (rst) cr_q <= '0;
    else     cr_q <= cr_d;
  end

  crlu_branch #(.NUM_FIELDS(NUM_FIELDS)) branch_i (
    .clk   (clk),
    .rst   (rst),
    .cr    (cr_q),
    .field (br_field),
    .cond  (br_cond),
    .taken (br_taken)
  );

  assign rd_data = cr_q;
endmodule

// File: rtl/crlu_checker.sv
module crlu_checker
  import crlu_pkg::*;
#(
  parameter  int NUM_FIELDS = 8,
  localparam int REG_W      = NUM_FIELDS * FLAG_W,
  localparam int IDX_W      = $clog2(REG_W),
  localparam int FSEL_W     = $clog2(NUM_FIELDS)
) (
  input logic              clk,
  input logic              rst,
  input logic              cmp_valid,
  input logic              cmp_named,
  input logic [FSEL_W-1:0] cmp_field,
  input logic              cmp_lt,
  input logic              cmp_gt,
  input logic              cmp_eq,
  input logic              cmp_so,
  input logic              op_valid,
  input logic [2:0]        op_code,
  input logic [IDX_W-1:0]  op_a,
  input logic [IDX_W-1:0]  op_b,
  input logic [IDX_W-1:0]  op_d,
  input logic              wr_en,
  input logic [REG_W-1:0]  wr_data,
  input logic [REG_W-1:0]  rd_data,
  input logic [FSEL_W-1:0] br_field,
  input logic [2:0]        br_cond,
  input logic              br_taken
);
  logic [REG_W-1:0]  rd_q;
  logic [FSEL_W-1:0] tgt_q, bf_q;
  logic [FLAG_W-1:0] flags_q, fld_now;
  logic [IDX_W-1:0]  d_q;
  logic [REG_W-1:0]  cmp_mask, bit_mask;
  logic              eq_old, gt_old;

  always_ff @(posedge clk) begin
    rd_q    <= rd_data;
    tgt_q   <= cmp_named ? cmp_field : '0;
    flags_q <= {cmp_lt, cmp_gt, cmp_eq, cmp_so};
    d_q     <= op_d;
    bf_q    <= br_field;
  end

  assign cmp_mask = {{(REG_W-FLAG_W){1'b0}}, {FLAG_W{1'b1}}} << ((NUM_FIELDS-1-int'(tgt_q))*FLAG_W);
  assign bit_mask = {{(REG_W-1){1'b0}}, 1'b1} << (REG_W-1-int'(d_q));
  assign fld_now  = rd_data[(NUM_FIELDS-1-int'(tgt_q))*FLAG_W +: FLAG_W];
  assign gt_old   = rd_q[REG_W-1-(int'(bf_q)*FLAG_W+1)];
  assign eq_old   = rd_q[REG_W-1-(int'(bf_q)*FLAG_W+2)];

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (rd_data == '0 && !br_taken));

  // R7 whole write, and R9 priority over every other source
  p_write_wins_r9: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> rd_data == $past(wr_data));

  p_cmp_field_r3: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && !wr_en && !op_valid) |=>
      (fld_now == flags_q && (rd_data & ~cmp_mask) == (rd_q & ~cmp_mask)));

  p_bitop_single_r4: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !wr_en && op_code != 3'd7) |=> ((rd_data ^ rd_q) & ~bit_mask) == '0);

  p_xor_self_r5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !wr_en && op_code == 3'd3 && op_a == op_b) |=> ((rd_data & bit_mask) == '0));

  p_xnor_self_r5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !wr_en && op_code == 3'd4 && op_a == op_b) |=> ((rd_data & bit_mask) != '0));

  p_br_ne_r8: assert property (@(posedge clk) disable iff (rst)
    (br_cond == 3'd6) |=> (br_taken == !eq_old));

  p_br_ge_r8: assert property (@(posedge clk) disable iff (rst)
    (br_cond == 3'd4) |=> (br_taken == (gt_old | eq_old)));
endmodule

bind crlu_top crlu_checker #(.NUM_FIELDS(NUM_FIELDS)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .cmp_valid (cmp_valid),
  .cmp_named (cmp_named),
  .cmp_field (cmp_field),
  .cmp_lt    (cmp_lt),
  .cmp_gt    (cmp_gt),
  .cmp_eq    (cmp_eq),
  .cmp_so    (cmp_so),
  .op_valid  (op_valid),
  .op_code   (op_code),
  .op_a      (op_a),
  .op_b      (op_b),
  .op_d      (op_d),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .br_field  (br_field),
  .br_cond   (br_cond),
  .br_taken  (br_taken)
);

// File: tb/crlu_top_tb_top.sv
`timescale 1ns/100ps
module crlu_top_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        cmp_valid, cmp_named, cmp_lt, cmp_gt, cmp_eq, cmp_so;
  logic [2:0]  cmp_field;
  logic        op_valid;
  logic [2:0]  op_code;
  logic [4:0]  op_a, op_b, op_d;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic [2:0]  br_field, br_cond;
  logic        br_taken;

  int n_checks = 0;
  int n_errors = 0;
  logic [31:0] cr_m = '0;
  logic [31:0] seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  crlu_top dut_i (
    .clk(clk), .rst(rst),
    .cmp_valid(cmp_valid), .cmp_named(cmp_named), .cmp_field(cmp_field),
    .cmp_lt(cmp_lt), .cmp_gt(cmp_gt), .cmp_eq(cmp_eq), .cmp_so(cmp_so),
    .op_valid(op_valid), .op_code(op_code), .op_a(op_a), .op_b(op_b), .op_d(op_d),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .br_field(br_field), .br_cond(br_cond), .br_taken(br_taken)
  );

  function automatic logic bit_of(logic [31:0] r, int g);
    return r[31-g];
  endfunction

  function automatic logic [31:0] model_next(logic [31:0] r);
    logic [31:0] x;
    logic a, b, y;
    int t;
    x = r;
    if (wr_en) return wr_data;
    if (op_valid) begin
      if (op_code == 3'd7) begin
        x[31-4*int'(op_d[2:0]) -: 4] = r[31-4*int'(op_a[2:0]) -: 4];
      end else begin
        a = bit_of(r, int'(op_a));
        b = bit_of(r, int'(op_b));
        case (op_code)
          3'd0: y = a & b;
          3'd1: y = a | b;
          3'd2: y = ~(a | b);
          3'd3: y = a ^ b;
          3'd4: y = ~(a ^ b);
          3'd5: y = a & ~b;
          default: y = a | ~b;
        endcase
        x[31-int'(op_d)] = y;
      end
    end else if (cmp_valid) begin
      t = cmp_named ? int'(cmp_field) : 0;
      x[31-4*t -: 4] = {cmp_lt, cmp_gt, cmp_eq, cmp_so};
    end
    return x;
  endfunction

  function automatic logic model_br(logic [31:0] r);
    logic [3:0] n;
    n = r[31-4*int'(br_field) -: 4];
    case (br_cond)
      3'd0: return n[3];
      3'd1: return n[2];
      3'd2: return n[1];
      3'd3: return n[0];
      3'd4: return n[2] | n[1];
      3'd5: return n[3] | n[1];
      3'd6: return ~n[1];
      default: return ~n[0];
    endcase
  endfunction

  task automatic idle();
    cmp_valid = 0; cmp_named = 0; cmp_field = 0;
    {cmp_lt, cmp_gt, cmp_eq, cmp_so} = 4'h0;
    op_valid = 0; op_code = 0; op_a = 0; op_b = 0; op_d = 0;
    wr_en = 0; wr_data = 0;
  endtask

  task automatic step(string tag);
    logic [31:0] nx;
    logic        bt;
    nx = model_next(cr_m);
    bt = model_br(cr_m);
    @(posedge clk);
    #1;
    cr_m = nx;
    n_checks++;
    if (rd_data !== nx || br_taken !== bt) begin
      n_errors++;
      $display("FAIL %s: rd_data=%h br_taken=%b expected rd_data=%h br_taken=%b",
               tag, rd_data, br_taken, nx, bt);
    end
    idle();
  endtask

  task automatic load_seed();
    seed = seed * 32'd1103515245 + 32'd12345;
    wr_en = 1; wr_data = seed ^ {seed[15:0], seed[31:16]};
    step("R7");
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    n_errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
    $finish;
  end

  initial begin
    idle();
    br_field = 0; br_cond = 0;
    rst = 1;
    wr_en = 1; wr_data = 32'hFFFF_FFFF;   // must be overridden by reset
    @(posedge clk); #1;
    @(posedge clk); #1;
    n_checks++;
    if (rd_data !== 32'h0 || br_taken !== 1'b0) begin
      n_errors++;
      $display("FAIL R1: rd_data=%h br_taken=%b expected 00000000 0", rd_data, br_taken);
    end
    rst = 0;
    idle();
    cr_m = '0;

    // R2 layout: field 7 equal bit is index 30 -> register bit 1
    cmp_valid = 1; cmp_named = 1; cmp_field = 3'd7; cmp_eq = 1;
    step("R2");
    op_valid = 1; op_code = 3'd4; op_a = 5'd0; op_b = 5'd0; op_d = 5'd0;
    step("R2");
    n_checks++;
    if (rd_data !== 32'h8000_0002) begin
      n_errors++;
      $display("FAIL R2: rd_data=%h expected 80000002", rd_data);
    end

    // R3 compare sweep, including unnamed with nonzero field number
    for (int nm = 0; nm < 2; nm++)
      for (int f = 0; f < 8; f++)
        for (int v = 0; v < 16; v++) begin
          cmp_valid = 1; cmp_named = nm[0]; cmp_field = f[2:0];
          {cmp_lt, cmp_gt, cmp_eq, cmp_so} = v[3:0];
          br_field = f[2:0]; br_cond = v[2:0];
          step("R3");
        end

    // R4/R5 bit operations
    for (int op = 0; op < 7; op++)
      for (int a = 0; a < 32; a++)
        for (int k = 0; k < 4; k++) begin
          load_seed();
          op_valid = 1; op_code = op[2:0]; op_a = a[4:0];
          op_b = (k == 0) ? a[4:0] : 5'((a + k * 9) % 32);
          op_d = (k == 0 && a[0]) ? a[4:0] : 5'((a * 5 + k * 11 + op) % 32);
          step(k == 0 ? "R5" : "R4");
        end

    // R6 field copy with upper index bits set
    for (int s = 0; s < 8; s++)
      for (int t = 0; t < 8; t++) begin
        load_seed();
        op_valid = 1; op_code = 3'd7;
        op_a = {2'b10, s[2:0]}; op_d = {2'b01, t[2:0]}; op_b = 5'd31;
        step("R6");
      end

    // R8 branch conditions over every field value
    for (int c = 0; c < 8; c++)
      for (int f = 0; f < 8; f++)
        for (int v = 0; v < 16; v++) begin
          wr_en = 1;
          wr_data = {8{~v[3:0]}};
          wr_data[31-4*f -: 4] = v[3:0];
          step("R7");
          br_field = f[2:0]; br_cond = c[2:0];
          step("R8");
        end

    // R8: a same-cycle write must not affect the decision
    br_field = 3'd2; br_cond = 3'd2;
    cmp_valid = 1; cmp_named = 1; cmp_field = 3'd2;
    {cmp_lt, cmp_gt, cmp_eq, cmp_so} = ~cr_m[31-8 -: 4];
    step("R8");
    step("R8");

    // R9 priority
    for (int i = 0; i < 8; i++) begin
      load_seed();
      wr_en = 1; wr_data = ~seed;
      op_valid = 1; op_code = 3'd4; op_a = 5'(i); op_b = 5'(i); op_d = 5'(i * 3);
      cmp_valid = 1; cmp_named = 1; cmp_field = 3'(i); {cmp_lt, cmp_gt, cmp_eq, cmp_so} = 4'(i);
      step("R9");
      op_valid = 1; op_code = 3'd7; op_a = 5'(i); op_d = 5'(7 - i);
      cmp_valid = 1; cmp_named = 1; cmp_field = 3'(7 - i); {cmp_lt, cmp_gt, cmp_eq, cmp_so} = 4'(~i);
      step("R9");
    end

    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule